// File: doc/BRIEF.md
# Tiled 7x7 Window Sum and Sum-of-Squares Engine

This block accepts one square tile of unsigned gray pixels in raster order, one pixel per accepted cycle. For every position where a full 7x7 neighbourhood fits inside the tile, it produces two results together. The first is the sum of the 49 gray values. The second is the sum of their squares. A downstream stage can derive a local mean and variance from this pair. Both results come from a single shared register window, so they always describe the same pixel position. Each result pair leaves the block with a one-cycle valid strobe and the coordinates of that result in the output grid.

Tiles are 32x32 pixels. The outer 3-pixel ring of each tile serves only as context for the interior, so a tile yields a 26x26 grid of results in row-major order. Six line stores hold the earlier rows of the tile, and a 7x7 register window slides along the current row. Input cycles without a valid pixel stall the pipeline. A start pulse begins a new tile at any time.

Top module: `tile_window_sums`

## Requirements
- R1: While reset is held, and after it is released, `out_valid` is low until a result is produced.
- R2: For a result at grid position (row a, column b), `out_sum` equals the sum of the tile pixels in rows a..a+6 and columns b..b+6. Tile rows and columns are counted from 0 in arrival order.
- R3: For the same result, `out_sumsq` equals the sum of the squares of those 49 pixels.
- R4: A result is produced for an accepted pixel at tile position (r, c) exactly when r >= 6 and c >= 6. It carries `out_row` = r-6 and `out_col` = c-6. A complete tile therefore yields 676 results in row-major order.
- R5: When the pixel completing a window is accepted at clock edge t, its result and `out_valid` are registered at edge t+1 and held for that one cycle only.
- R6: A cycle with `pix_valid` low advances nothing. The cycle after it carries no result.
- R7: A window of all-255 pixels gives `out_sum` = 12495 and `out_sumsq` = 3186225, with no wrap.
- R8: After the 1024th pixel of a tile, further `pix_valid` cycles are ignored and produce no result until `tile_start` is pulsed.
- R9: `tile_start` restarts the tile position counters. A pixel presented in the same cycle is pixel (0,0) of the new tile. An abandoned partial tile has no effect on the new tile's results.
- R10: Out of reset, the block is ready at tile position (0,0) without any `tile_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tile_start | input | 1 | Begin a new tile at position (0,0) |
| pix_valid | input | 1 | `pix_data` holds a pixel this cycle |
| pix_data | input | 8 | Unsigned gray value |
| out_valid | output | 1 | Result pair valid this cycle |
| out_row | output | 5 | Result grid row, 0..25 |
| out_col | output | 5 | Result grid column, 0..25 |
| out_sum | output | 14 | Sum of the 49 window pixels |
| out_sumsq | output | 22 | Sum of the squares of the 49 window pixels |

## Verification
The hardest situation to reach is a new tile starting while the line stores and the window still hold pixels from an abandoned partial tile. Only correct gating of the output by position keeps that stale data out of the results. The stimulus first feeds a partial tile of random pixels deep enough to produce results. It then pulses `tile_start` together with the first pixel of a fresh random tile and compares all 676 new results against a reference computed from the stored tile. A separate run pushes extra pixels past the end of a tile, and another inserts idle cycles between pixels. These runs show that the sliding window advances only on accepted pixels.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    // Bits needed for the sum of K*K unsigned pixels of width pw.
    function automatic int sum_bits(input int pw, input int k);
        return $clog2(k * k * ((1 << pw) - 1) + 1);
    endfunction

    // Bits needed for the sum of K*K squared pixels of width pw.
    function automatic int sq_bits(input int pw, input int k);
        return $clog2(k * k * ((1 << pw) - 1) * ((1 << pw) - 1) + 1);
    endfunction

endpackage

// File: rtl/tsw_line_store.sv
// Holds the previous DEPTH rows of the tile, one entry per column.
// On each accepted pixel the column at `col` shifts down by one row.
module tsw_line_store #(
    parameter int PIX_W = 8,
    parameter int TILE  = 32,
    parameter int DEPTH = 6,
    localparam int POS_W = $clog2(TILE)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift,
    input  logic [POS_W-1:0]              col,
    input  logic [PIX_W-1:0]              pix_in,
    // col_out[0] is the current pixel, col_out[k] is the pixel k rows up
    output logic [DEPTH:0][PIX_W-1:0]     col_out
);

    typedef logic [DEPTH-1:0][TILE-1:0][PIX_W-1:0] store_t;

    store_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (shift) begin
            mem_d[0][col] = pix_in;
            for (int k = 1; k < DEPTH; k++) begin
                mem_d[k][col] = mem_q[k-1][col];
            end
        end
    end

    always_comb begin
        col_out[0] = pix_in;
        for (int k = 1; k <= DEPTH; k++) begin
            col_out[k] = mem_q[k-1][col];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

endmodule

// File: rtl/tsw_window.sv
// KxK register window; the newest column enters at the right edge.
module tsw_window #(
    parameter int PIX_W = 8,
    parameter int TILE  = 32,
    parameter int K     = 7,
    localparam int POS_W   = $clog2(TILE),
    localparam int OUT_DIM = TILE - K + 1,
    localparam int OUT_W   = $clog2(OUT_DIM)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              shift,
    input  logic [K-1:0][PIX_W-1:0]           col_in,   // [k] = k rows above current
    input  logic [POS_W-1:0]                  row,
    input  logic [POS_W-1:0]                  col,
    output logic [K-1:0][K-1:0][PIX_W-1:0]    win,      // [i][j]: i from top row, j from left
    output logic                              win_vld,
    output logic [OUT_W-1:0]                  win_row,
    output logic [OUT_W-1:0]                  win_col
);

    typedef struct packed {
        logic [K-1:0][K-1:0][PIX_W-1:0] px;
        logic                           vld;
        logic [OUT_W-1:0]               orow;
        logic [OUT_W-1:0]               ocol;
    } win_t;

    win_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (shift) begin
            for (int i = 0; i < K; i++) begin
                for (int j = 0; j < K - 1; j++) begin
                    s_d.px[i][j] = s_q.px[i][j+1];
                end
                s_d.px[i][K-1] = col_in[K-1-i];
            end
            s_d.vld  = (row >= POS_W'(K - 1)) && (col >= POS_W'(K - 1));
            s_d.orow = OUT_W'(row - POS_W'(K - 1));
            s_d.ocol = OUT_W'(col - POS_W'(K - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign win     = s_q.px;
    assign win_vld = s_q.vld;
    assign win_row = s_q.orow;
    assign win_col = s_q.ocol;

endmodule

// File: rtl/tsw_sum_tree.sv
// Squares every window pixel, reduces columns then the row of column
// totals, and registers the pair with its coordinates.
module tsw_sum_tree #(
    parameter int PIX_W = 8,
    parameter int K     = 7,
    parameter int OUT_W = 5,
    parameter int SUM_W = 14,
    parameter int SQ_W  = 22
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [K-1:0][K-1:0][PIX_W-1:0]    win,
    input  logic                              win_vld,
    input  logic [OUT_W-1:0]                  win_row,
    input  logic [OUT_W-1:0]                  win_col,
    output logic                              res_vld,
    output logic [OUT_W-1:0]                  res_row,
    output logic [OUT_W-1:0]                  res_col,
    output logic [SUM_W-1:0]                  res_sum,
    output logic [SQ_W-1:0]                   res_sumsq
);

    localparam int SQP_W = 2 * PIX_W;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] row;
        logic [OUT_W-1:0] col;
        logic [SUM_W-1:0] sum;
        logic [SQ_W-1:0]  sumsq;
    } res_t;

    res_t r_d, r_q;

    logic [K-1:0][K-1:0][SQP_W-1:0] sq;
    logic [K-1:0][SUM_W-1:0]        col_sum;
    logic [K-1:0][SQ_W-1:0]         col_sq;
    logic [SUM_W-1:0]               tot_sum;
    logic [SQ_W-1:0]                tot_sq;

    for (genvar i = 0; i < K; i++) begin : g_sq_row
        for (genvar j = 0; j < K; j++) begin : g_sq_col
            assign sq[i][j] = SQP_W'(win[i][j]) * SQP_W'(win[i][j]);
        end
    end

    // First level: one adder chain per window column.
    for (genvar j = 0; j < K; j++) begin : g_col
        always_comb begin
            col_sum[j] = '0;
            col_sq[j]  = '0;
            for (int i = 0; i < K; i++) begin
                col_sum[j] = col_sum[j] + SUM_W'(win[i][j]);
                col_sq[j]  = col_sq[j]  + SQ_W'(sq[i][j]);
            end
        end
    end

    // Second level: combine the column totals.
    always_comb begin
        tot_sum = '0;
        tot_sq  = '0;
        for (int j = 0; j < K; j++) begin
            tot_sum = tot_sum + col_sum[j];
            tot_sq  = tot_sq  + col_sq[j];
        end
    end

    always_comb begin
        r_d = r_q;
        r_d.vld = win_vld;
        if (win_vld) begin
            r_d.row   = win_row;
            r_d.col   = win_col;
            r_d.sum   = tot_sum;
            r_d.sumsq = tot_sq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_vld   = r_q.vld;
    assign res_row   = r_q.row;
    assign res_col   = r_q.col;
    assign res_sum   = r_q.sum;
    assign res_sumsq = r_q.sumsq;

endmodule

// File: rtl/tile_window_sums.sv
module tile_window_sums #(
    parameter int PIX_W = 8,
    parameter int TILE  = 32,
    parameter int K     = 7,
    localparam int POS_W   = $clog2(TILE),
    localparam int OUT_DIM = TILE - K + 1,
    localparam int OUT_W   = $clog2(OUT_DIM),
    localparam int SUM_W   = tsw_pkg::sum_bits(PIX_W, K),
    localparam int SQ_W    = tsw_pkg::sq_bits(PIX_W, K)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tile_start,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_row,
    output logic [OUT_W-1:0]  out_col,
    output logic [SUM_W-1:0]  out_sum,
    output logic [SQ_W-1:0]   out_sumsq
);

    typedef struct packed {
        logic [POS_W-1:0] row;
        logic [POS_W-1:0] col;
        logic             done;
    } pos_t;

    pos_t pos_d, pos_q, pos_base;
    logic accept;

    logic [K-1:0][PIX_W-1:0]        column;
    logic [K-1:0][K-1:0][PIX_W-1:0] win;
    logic                           win_vld;
    logic [OUT_W-1:0]               win_row, win_col;

    // Tile position tracking; tile_start overrides the held position.
    always_comb begin
        pos_base = tile_start ? pos_t'('0) : pos_q;
        accept   = pix_valid && !pos_base.done;
        pos_d    = pos_base;
        if (accept) begin
            if (pos_base.col == POS_W'(TILE - 1)) begin
                pos_d.col = '0;
                if (pos_base.row == POS_W'(TILE - 1)) begin
                    pos_d.row  = '0;
                    pos_d.done = 1'b1;
                end else begin
                    pos_d.row = pos_base.row + POS_W'(1);
                end
            end else begin
                pos_d.col = pos_base.col + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    tsw_line_store #(
        .PIX_W (PIX_W),
        .TILE  (TILE),
        .DEPTH (K - 1)
    ) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (accept),
        .col     (pos_base.col),
        .pix_in  (pix_data),
        .col_out (column)
    );

    tsw_window #(
        .PIX_W (PIX_W),
        .TILE  (TILE),
        .K     (K)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (accept),
        .col_in  (column),
        .row     (pos_base.row),
        .col     (pos_base.col),
        .win     (win),
        .win_vld (win_vld),
        .win_row (win_row),
        .win_col (win_col)
    );

    tsw_sum_tree #(
        .PIX_W (PIX_W),
        .K     (K),
        .OUT_W (OUT_W),
        .SUM_W (SUM_W),
        .SQ_W  (SQ_W)
    ) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .win       (win),
        .win_vld   (win_vld),
        .win_row   (win_row),
        .win_col   (win_col),
        .res_vld   (out_valid),
        .res_row   (out_row),
        .res_col   (out_col),
        .res_sum   (out_sum),
        .res_sumsq (out_sumsq)
    );

endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
    parameter int PIX_W = 8,
    parameter int TILE  = 32,
    parameter int K     = 7,
    localparam int OUT_DIM = TILE - K + 1,
    localparam int OUT_W   = $clog2(OUT_DIM),
    localparam int SUM_W   = tsw_pkg::sum_bits(PIX_W, K),
    localparam int SQ_W    = tsw_pkg::sq_bits(PIX_W, K)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_row,
    input logic [OUT_W-1:0] out_col,
    input logic [SUM_W-1:0] out_sum,
    input logic [SQ_W-1:0]  out_sumsq
);

    localparam int MAX_PIX = (1 << PIX_W) - 1;
    localparam int MAX_SUM = K * K * MAX_PIX;
    localparam int MAX_SQ  = K * K * MAX_PIX * MAX_PIX;

    // R4: coordinates stay inside the result grid
    p_coords_in_grid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_row) < OUT_DIM) && (int'(out_col) < OUT_DIM));

    // R4: back-to-back results step one column along the same row
    p_row_major_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |->
            (out_row == $past(out_row)) && (out_col == $past(out_col) + OUT_W'(1)));

    // R7: results never exceed the full-scale window values
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_sum) <= MAX_SUM) && (int'(out_sumsq) <= MAX_SQ));

    // R3: an integer square is never below the integer itself
    p_sq_not_below_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sumsq >= {{(SQ_W-SUM_W){1'b0}}, out_sum});

    // R5: every result traces back to a pixel offered two samples earlier
    p_result_follows_pixel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid, 2));

    // R6: an idle input cycle yields no result afterwards
    p_idle_gives_nothing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> ##2 !out_valid);

endmodule

bind tile_window_sums tsw_checker #(
    .PIX_W (PIX_W),
    .TILE  (TILE),
    .K     (K)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .out_valid (out_valid),
    .out_row   (out_row),
    .out_col   (out_col),
    .out_sum   (out_sum),
    .out_sumsq (out_sumsq)
);

// File: tb/tile_window_sums_bench.sv
module tile_window_sums_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tile_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_data = '0;
    logic        out_valid;
    logic [4:0]  out_row, out_col;
    logic [13:0] out_sum;
    logic [21:0] out_sumsq;

    int tests = 0;
    int fails = 0;
    int seen  = 0;
    bit finished = 1'b0;

    logic [7:0] tile [32][32];

    // expected-result pipeline slots: driven one and two cycles ago
    bit d1_v = 0, d2_v = 0;
    int d1_r = 0, d1_c = 0, d2_r = 0, d2_c = 0;
    string idle_req = "R1";

    always #2 clk = ~clk;

    tile_window_sums u_tile_window_sums (
        .clk        (clk),
        .rst_n      (rst_n),
        .tile_start (tile_start),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .out_valid  (out_valid),
        .out_row    (out_row),
        .out_col    (out_col),
        .out_sum    (out_sum),
        .out_sumsq  (out_sumsq)
    );

    function automatic int ref_sum(int a, int b);
        int s = 0;
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++) s += int'(tile[a+i][b+j]);
        return s;
    endfunction

    function automatic int ref_sq(int a, int b);
        int s = 0;
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++) s += int'(tile[a+i][b+j]) * int'(tile[a+i][b+j]);
        return s;
    endfunction

    task automatic check_outputs();
        bit bad = 0;
        tests++;
        if (d2_v) begin
            if (!out_valid || int'(out_row) != d2_r || int'(out_col) != d2_c) begin
                bad = 1;
                $display("FAIL R4 R5 valid/pos: got v=%0d (%0d,%0d) expected v=1 (%0d,%0d)",
                         out_valid, out_row, out_col, d2_r, d2_c);
            end else begin
                seen++;
                if (int'(out_sum) != ref_sum(d2_r, d2_c)) begin
                    bad = 1;
                    $display("FAIL R2 sum at (%0d,%0d): got %0d expected %0d",
                             d2_r, d2_c, out_sum, ref_sum(d2_r, d2_c));
                end
                if (int'(out_sumsq) != ref_sq(d2_r, d2_c)) begin
                    bad = 1;
                    $display("FAIL R3 sumsq at (%0d,%0d): got %0d expected %0d",
                             d2_r, d2_c, out_sumsq, ref_sq(d2_r, d2_c));
                end
            end
        end else if (out_valid) begin
            bad = 1;
            $display("FAIL %s unexpected result: got v=1 (%0d,%0d) expected v=0",
                     idle_req, out_row, out_col);
        end
        if (bad) fails++;
    endtask

    task automatic cycle(bit v, logic [7:0] p, bit start, bit ex, int er, int ec);
        @(negedge clk);
        check_outputs();
        pix_valid  = v;
        pix_data   = p;
        tile_start = start;
        d2_v = d1_v; d2_r = d1_r; d2_c = d1_c;
        d1_v = ex;   d1_r = er;   d1_c = ec;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(0, '0, 0, 0, 0, 0);
    endtask

    // Feed the stored tile; gap>0 inserts an idle cycle before every gap-th pixel.
    task automatic feed_tile(bit with_start, int gap, int npix);
        int k = 0;
        for (int r = 0; r < 32; r++) begin
            for (int c = 0; c < 32; c++) begin
                if (k < npix) begin
                    if (gap > 0 && (k % gap) == gap - 1) cycle(0, '0, 0, 0, 0, 0);
                    cycle(1, tile[r][c], with_start && k == 0, r >= 6 && c >= 6, r - 6, c - 6);
                end
                k++;
            end
        end
    endtask

    task automatic count_check(string req, int expected);
        tests++;
        if (seen != expected) begin
            fails++;
            $display("FAIL %s result count: got %0d expected %0d", req, seen, expected);
        end
        seen = 0;
    endtask

    task automatic fill_random();
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 32; c++) tile[r][c] = 8'($urandom);
    endtask

    // R1: no result during or just after reset
    task automatic t_reset();
        idle_req = "R1";
        idle(4);
    endtask

    // R10: first tile accepted straight out of reset, no start pulse; R2 R3 R4 R5
    task automatic t_first_tile();
        idle_req = "R4";
        fill_random();
        feed_tile(0, 0, 1024);
        idle(3);
        count_check("R10", 676);
    endtask

    // R7: full-scale tile, spot value check as well as per-result reference
    task automatic t_full_scale();
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 32; c++) tile[r][c] = 8'hFF;
        idle_req = "R4";
        feed_tile(1, 0, 1024);
        idle(3);
        count_check("R7", 676);
        tests++;
        if (ref_sum(0, 0) != 12495 || ref_sq(0, 0) != 3186225) begin
            fails++;
            $display("FAIL R7 reference: got %0d/%0d expected 12495/3186225",
                     ref_sum(0, 0), ref_sq(0, 0));
        end
    endtask

    // R6: idle cycles between pixels stall the window
    task automatic t_gaps();
        fill_random();
        idle_req = "R6";
        feed_tile(1, 3, 1024);
        idle(3);
        count_check("R6", 676);
    endtask

    // R8: surplus pixels after a full tile are ignored
    task automatic t_overrun();
        fill_random();
        idle_req = "R4";
        feed_tile(1, 0, 1024);
        idle_req = "R8";
        for (int i = 0; i < 40; i++) cycle(1, 8'($urandom), 0, 0, 0, 0);
        idle(3);
        count_check("R8", 676);
    endtask

    // R9: abandon a partial tile, then restart with a pixel in the start cycle
    task automatic t_restart();
        fill_random();
        idle_req = "R4";
        feed_tile(1, 0, 300);
        idle(3);
        count_check("R9", 3 * 26 + 6);
        fill_random();
        feed_tile(1, 0, 1024);
        idle(3);
        count_check("R9", 676);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 during reset: got %0b expected 0", out_valid);
        end
        rst_n = 1'b1;
        t_reset();
        t_first_tile();
        t_full_scale();
        t_gaps();
        t_overrun();
        t_restart();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule